// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a down-counting interval timer with automatic reload. An 8-bit counter steps down once for each pulse from a selected count source. When a pulse arrives while the counter already holds zero, the counter takes a fresh value from a companion reload register, emits a one-clock underflow pulse and latches an interrupt request flag. The counter then keeps running, so a loaded value n yields one underflow every n+1 source pulses.

Software reaches the block through two write paths. One loads the counter and the reload register together. The other changes only the reload value, and the new period takes effect at the next underflow. A small control register picks one of four count sources, turns counting on and off, and can make counting wait for an armed signal from an external start synchronizer.

The request flag either raises an interrupt or is polled, depending on an enable input. It is cleared by an interrupt acknowledge or by a skip test strobe.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the counter, the reload register, the control register and the request flag are all zero, and underflowPulse and intReq are low.
- R2: A combined write (loadBothEn) puts loadBothData into both the counter and the reload register; countOut shows the value one clock later.
- R3: A reload-only write (loadReloadEn) leaves the counter unchanged, and the next underflow reloads the counter from the newly written value.
- R4: Control bit 3 is the run bit and bits 1:0 select srcPulse[bits 1:0] as the count source. Pulses on unselected sources are ignored. With the run bit at 0 the counter holds its value.
- R5: With control bit 2 set, a selected source pulse is counted only while startArmed is high.
- R6: With loaded value n, one underflow occurs for every n+1 counted pulses.
- R7: A counted pulse while the counter is zero is an underflow. On the next clock the counter holds the reload value, underflowPulse is high for that one clock and reqFlag is 1.
- R8: A high intAck or skipTest clears reqFlag on the next clock. If an underflow happens in the same cycle, the flag stays set.
- R9: intReq is high exactly when reqFlag is 1 and intEnable is high.
- R10: A combined write takes priority over a counted pulse in the same cycle: no decrement and no underflow occur. It also takes priority over a simultaneous reload-only write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loadBothEn | input | 1 | Strobe: write the counter and the reload register |
| loadBothData | input | 8 | Value for the combined write |
| loadReloadEn | input | 1 | Strobe: write the reload register only |
| loadReloadData | input | 8 | Value for the reload-only write |
| ctrlWrEn | input | 1 | Strobe: write the control register |
| ctrlWrData | input | 4 | Control value: [1:0] source, [2] wait for start, [3] run |
| srcPulse | input | 4 | Single-cycle count enable pulses, one per source |
| startArmed | input | 1 | Armed state of the external start synchronizer |
| intEnable | input | 1 | Flag drives an interrupt (1) or is polled (0) |
| intAck | input | 1 | Interrupt accepted: clear the flag |
| skipTest | input | 1 | Skip test performed: clear the flag |
| countOut | output | 8 | Current counter value |
| underflowPulse | output | 1 | One-clock pulse per underflow |
| reqFlag | output | 1 | Request flag |
| intReq | output | 1 | Interrupt request to the interrupt controller |

## Verification
Two pairs of events can collide in one cycle. The first is an underflow landing on the same clock as a flag-clearing strobe. The second is a combined write arriving with a counted pulse, or together with a reload-only write. The directed part of the bench runs the counter down to zero and then fires the tick together with intAck, and separately together with loadBothEn and loadReloadEn. It judges the flag, the counter and the later reload value against constants derived from the priority rules in R8 and R10. The random part mixes all strobes densely with short periods, so these collisions recur, and compares every output every cycle with a bench-side model.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  // Strobes from the control unit to the datapath; at most one of the
  // counter-changing actions is asserted in any cycle.
  typedef struct packed {
    logic loadBoth;      // load counter and reload from the combined write
    logic loadReload;    // load reload register only
    logic decrement;     // counted pulse, counter not zero
    logic reloadFromReg; // counted pulse at zero: underflow
  } dpStrobe_t;

endpackage

// File: rtl/rdt_datapath.sv
module rdt_datapath
  import rdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadBothData,
  input  logic [CNT_W-1:0] loadReloadData,
  output logic [CNT_W-1:0] countOut,
  output logic             cntZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] reloadReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countReg <= '0;
    end else if (strobe.loadBoth) begin
      countReg <= loadBothData;
    end else if (strobe.reloadFromReg) begin
      countReg <= reloadReg;
    end else if (strobe.decrement) begin
      countReg <= countReg - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloadReg <= '0;
    end else if (strobe.loadBoth) begin
      reloadReg <= loadBothData;
    end else if (strobe.loadReload) begin
      reloadReg <= loadReloadData;
    end
  end

  assign countOut = countReg;
  assign cntZero  = (countReg == '0);

endmodule

// File: rtl/rdt_ctrl.sv
module rdt_ctrl
  import rdt_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int CTRL_W  = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               startArmed,
  input  logic               loadBothEn,
  input  logic               loadReloadEn,
  input  logic               cntZero,
  input  logic               intEnable,
  input  logic               intAck,
  input  logic               skipTest,
  output dpStrobe_t          strobe,
  output logic               underflowPulse,
  output logic               reqFlag,
  output logic               intReq,
  output logic               runBit,
  output logic               extStartBit
);

  localparam int RUN_POS = SEL_W + 1;
  localparam int EXT_POS = SEL_W;

  logic [CTRL_W-1:0]  ctrlReg;
  logic [SEL_W-1:0]   srcSel;
  logic [NUM_SRC-1:0] selHit;
  logic               srcTick;
  logic               countTick;
  logic               flagClear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
    end else if (ctrlWrEn) begin
      ctrlReg <= ctrlWrData;
    end
  end

  assign srcSel      = ctrlReg[SEL_W-1:0];
  assign extStartBit = ctrlReg[EXT_POS];
  assign runBit      = ctrlReg[RUN_POS];

  // One comparator per source; the selected pulse survives.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrcSel
    assign selHit[g] = srcPulse[g] && (srcSel == SEL_W'(g));
  end

  assign srcTick   = |selHit;
  assign countTick = runBit && srcTick && (!extStartBit || startArmed);

  always_comb begin
    strobe               = '0;
    strobe.loadBoth      = loadBothEn;
    strobe.loadReload    = loadReloadEn && !loadBothEn;
    strobe.decrement     = countTick && !loadBothEn && !cntZero;
    strobe.reloadFromReg = countTick && !loadBothEn && cntZero;
  end

  assign flagClear = intAck || skipTest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underflowPulse <= 1'b0;
      reqFlag        <= 1'b0;
    end else begin
      underflowPulse <= strobe.reloadFromReg;
      if (strobe.reloadFromReg) begin
        reqFlag <= 1'b1;
      end else if (flagClear) begin
        reqFlag <= 1'b0;
      end
    end
  end

  assign intReq = reqFlag && intEnable;

endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import rdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int CTRL_W  = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loadBothEn,
  input  logic [CNT_W-1:0]   loadBothData,
  input  logic               loadReloadEn,
  input  logic [CNT_W-1:0]   loadReloadData,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               startArmed,
  input  logic               intEnable,
  input  logic               intAck,
  input  logic               skipTest,
  output logic [CNT_W-1:0]   countOut,
  output logic               underflowPulse,
  output logic               reqFlag,
  output logic               intReq
);

  dpStrobe_t strobe;
  logic      cntZero;
  logic      runBit;
  logic      extStartBit;

  rdt_ctrl #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W),
    .CTRL_W  (CTRL_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrlWrEn       (ctrlWrEn),
    .ctrlWrData     (ctrlWrData),
    .srcPulse       (srcPulse),
    .startArmed     (startArmed),
    .loadBothEn     (loadBothEn),
    .loadReloadEn   (loadReloadEn),
    .cntZero        (cntZero),
    .intEnable      (intEnable),
    .intAck         (intAck),
    .skipTest       (skipTest),
    .strobe         (strobe),
    .underflowPulse (underflowPulse),
    .reqFlag        (reqFlag),
    .intReq         (intReq),
    .runBit         (runBit),
    .extStartBit    (extStartBit)
  );

  rdt_datapath #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .loadBothData   (loadBothData),
    .loadReloadData (loadReloadData),
    .countOut       (countOut),
    .cntZero        (cntZero)
  );

endmodule

// File: rtl/rdt_checker.sv
module rdt_checker
  import rdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loadBothEn,
  input logic [CNT_W-1:0] loadBothData,
  input logic             loadReloadEn,
  input logic             startArmed,
  input logic             intAck,
  input logic             skipTest,
  input logic [CNT_W-1:0] countOut,
  input logic             underflowPulse,
  input logic             reqFlag,
  input logic             runBit,
  input logic             extStartBit,
  input dpStrobe_t        strobe
);

  AST_LOAD_BOTH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    loadBothEn |=> countOut == $past(loadBothData)); // R2

  AST_RELOAD_ONLY_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (loadReloadEn && !loadBothEn && !strobe.decrement && !strobe.reloadFromReg)
      |=> $stable(countOut)); // R3

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!runBit && !loadBothEn) |=> $stable(countOut)); // R4

  AST_UNARMED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (runBit && extStartBit && !startArmed && !loadBothEn) |=> $stable(countOut)); // R5

  AST_UF_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    underflowPulse |-> $past(countOut) == '0); // R7

  AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    underflowPulse |-> reqFlag); // R7

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqFlag && (intAck || skipTest)) |=> (!reqFlag || underflowPulse)); // R8

endmodule

bind reload_down_timer rdt_checker #(.CNT_W(CNT_W)) u_rdt_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .loadBothEn     (loadBothEn),
  .loadBothData   (loadBothData),
  .loadReloadEn   (loadReloadEn),
  .startArmed     (startArmed),
  .intAck         (intAck),
  .skipTest       (skipTest),
  .countOut       (countOut),
  .underflowPulse (underflowPulse),
  .reqFlag        (reqFlag),
  .runBit         (runBit),
  .extStartBit    (extStartBit),
  .strobe         (strobe)
);

// File: tb/reload_down_timer_bench.sv
module reload_down_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loadBothEn = 1'b0;
  logic [7:0] loadBothData = '0;
  logic       loadReloadEn = 1'b0;
  logic [7:0] loadReloadData = '0;
  logic       ctrlWrEn = 1'b0;
  logic [3:0] ctrlWrData = '0;
  logic [3:0] srcPulse = '0;
  logic       startArmed = 1'b0;
  logic       intEnable = 1'b0;
  logic       intAck = 1'b0;
  logic       skipTest = 1'b0;
  logic [7:0] countOut;
  logic       underflowPulse;
  logic       reqFlag;
  logic       intReq;

  int checks = 0;
  int errors = 0;

  // bench-side model state
  logic [7:0] mCount = '0;
  logic [7:0] mReload = '0;
  logic [3:0] mCtrl = '0;
  logic       mFlag = 1'b0;
  logic       mUf = 1'b0;

  always #5ns clk = ~clk;

  reload_down_timer u_reload_down_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .loadBothEn     (loadBothEn),
    .loadBothData   (loadBothData),
    .loadReloadEn   (loadReloadEn),
    .loadReloadData (loadReloadData),
    .ctrlWrEn       (ctrlWrEn),
    .ctrlWrData     (ctrlWrData),
    .srcPulse       (srcPulse),
    .startArmed     (startArmed),
    .intEnable      (intEnable),
    .intAck         (intAck),
    .skipTest       (skipTest),
    .countOut       (countOut),
    .underflowPulse (underflowPulse),
    .reqFlag        (reqFlag),
    .intReq         (intReq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Next counter value as the requirements define it.
  function automatic logic [7:0] nextCount(logic tick);
    if (loadBothEn) return loadBothData;
    if (tick && mCount == 8'd0) return mReload;
    if (tick) return mCount - 8'd1;
    return mCount;
  endfunction

  function automatic logic [7:0] nextReload();
    if (loadBothEn) return loadBothData;
    if (loadReloadEn) return loadReloadData;
    return mReload;
  endfunction

  // One clock: predict from current inputs, advance, compare, drop strobes.
  task automatic cyc();
    logic tick;
    logic [7:0] nC;
    logic [7:0] nR;
    logic nF;
    logic uf;
    tick = mCtrl[3] && srcPulse[mCtrl[1:0]] && (!mCtrl[2] || startArmed);
    uf = tick && !loadBothEn && (mCount == 8'd0);
    nC = nextCount(tick);
    nR = nextReload();
    nF = uf ? 1'b1 : ((intAck || skipTest) ? 1'b0 : mFlag);
    @(posedge clk);
    #1ns;
    mCount = nC;
    mReload = nR;
    mFlag = nF;
    mUf = uf;
    if (ctrlWrEn) mCtrl = ctrlWrData;
    check("R6 count", int'(countOut), int'(mCount));
    check("R7 underflow", int'(underflowPulse), int'(mUf));
    check("R8 flag", int'(reqFlag), int'(mFlag));
    check("R9 intReq", int'(intReq), int'(mFlag && intEnable));
    loadBothEn = 1'b0;
    loadReloadEn = 1'b0;
    ctrlWrEn = 1'b0;
    srcPulse = '0;
    intAck = 1'b0;
    skipTest = 1'b0;
  endtask

  task automatic tick0(int n);
    for (int i = 0; i < n; i++) begin
      srcPulse = 4'b0001;
      cyc();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1ns;
    rst_n = 1'b1;
    // R1 reset state
    check("R1 count", int'(countOut), 0);
    check("R1 flag", int'(reqFlag), 0);
    check("R1 uf", int'(underflowPulse), 0);
    check("R1 intReq", int'(intReq), 0);
    srcPulse = 4'b1111;   // control is zero after reset: nothing counts
    cyc();
    check("R1 no count after reset", int'(countOut), 0);

    // R2 combined write
    loadBothEn = 1'b1; loadBothData = 8'd5; cyc();
    check("R2 count loaded", int'(countOut), 5);

    ctrlWrEn = 1'b1; ctrlWrData = 4'b1000; cyc();  // run, source 0
    tick0(5);
    check("R6 at zero after n ticks", int'(countOut), 0);
    check("R6 no uf yet", int'(underflowPulse), 0);
    tick0(1);
    check("R7 reload value", int'(countOut), 5);
    check("R7 uf pulse", int'(underflowPulse), 1);
    check("R7 flag set", int'(reqFlag), 1);
    cyc();
    check("R7 pulse one clock", int'(underflowPulse), 0);

    // R4 unselected source ignored
    srcPulse = 4'b1110; cyc();
    check("R4 other source ignored", int'(countOut), 5);

    // R3 reload-only write
    tick0(2);
    loadReloadEn = 1'b1; loadReloadData = 8'd9; cyc();
    check("R3 count untouched", int'(countOut), 3);
    tick0(3);
    tick0(1);
    check("R3 new reload used", int'(countOut), 9);

    // R8 skip clear, then collision with underflow
    skipTest = 1'b1; cyc();
    check("R8 skip clears", int'(reqFlag), 0);
    tick0(9);
    intAck = 1'b1; srcPulse = 4'b0001; cyc();
    check("R8 set wins", int'(reqFlag), 1);
    intEnable = 1'b1; cyc();
    check("R9 intReq high", int'(intReq), 1);
    intAck = 1'b1; cyc();
    check("R8 ack clears", int'(reqFlag), 0);
    check("R9 intReq low", int'(intReq), 0);
    intEnable = 1'b0;

    // R4 stop freezes
    ctrlWrEn = 1'b1; ctrlWrData = 4'b0000; cyc();
    tick0(3);
    check("R4 frozen", int'(countOut), 9);

    // R5 external start gating
    ctrlWrEn = 1'b1; ctrlWrData = 4'b1100; cyc();
    startArmed = 1'b0; tick0(2);
    check("R5 unarmed holds", int'(countOut), 9);
    startArmed = 1'b1; tick0(1);
    check("R5 armed counts", int'(countOut), 8);
    ctrlWrEn = 1'b1; ctrlWrData = 4'b1000; cyc();

    // R10 priorities
    loadBothEn = 1'b1; loadBothData = 8'd2;
    loadReloadEn = 1'b1; loadReloadData = 8'd7;
    srcPulse = 4'b0001; cyc();
    check("R10 load beats tick", int'(countOut), 2);
    tick0(2);
    loadBothEn = 1'b1; loadBothData = 8'd4; srcPulse = 4'b0001; cyc();
    check("R10 no uf on load", int'(underflowPulse), 0);
    check("R10 load at zero", int'(countOut), 4);
    tick0(5);
    check("R10 combined reload kept", int'(countOut), 4);

    // source 2 selected
    ctrlWrEn = 1'b1; ctrlWrData = 4'b1010; cyc();
    srcPulse = 4'b0100; cyc();
    check("R4 source 2 counts", int'(countOut), 3);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      srcPulse = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 39) == 0) begin
        loadBothEn = 1'b1; loadBothData = 8'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 24) == 0) begin
        loadReloadEn = 1'b1; loadReloadData = 8'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 59) == 0) begin
        ctrlWrEn = 1'b1;
        ctrlWrData = {($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
                      2'($urandom_range(0, 3))};
      end
      if ($urandom_range(0, 7) == 0) startArmed = ~startArmed;
      if ($urandom_range(0, 49) == 0) intEnable = ~intEnable;
      intAck = ($urandom_range(0, 9) == 0);
      skipTest = ($urandom_range(0, 9) == 0);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule